// File: doc/BRIEF.md
# Pipelined Interrupt Winner Selector with Write Interlock

This block selects the best pending interrupt for a core-local interrupt controller. Each source holds four fields: a pending flag, an enable flag, a target privilege mode and an 8-bit level. A write port updates all four fields of one source in a single cycle. A radix-2 comparison tree reduces all sources to one winner. The tree has a register stage after every two comparison levels, so large source counts still meet clock speed.

The registered tree lags the field storage by several cycles. An interlock counter hides that lag. Any field write starts a busy window that lasts exactly as long as the tree pipeline. During that window the next-interrupt outputs and the trap request are held inactive. The first output seen after a write therefore already reflects it, so every write looks immediate to a consumer that honours the valid and busy signals.

The winner also goes through a trap qualifier. This qualifier compares its level against a threshold and the level now being serviced, and checks its mode against the current privilege and the per-mode global interrupt enables.

Top module: `irq_select_top`

## Requirements
- R1: A source is eligible only while both its pending flag and its enable flag are 1. Whenever `nxt_valid` is 1, `nxt_id` names an eligible source.
- R2: Among eligible sources the winner has the greatest mode value. Among those with the greatest mode it has the greatest level. `nxt_mode` and `nxt_level` report the winner's fields.
- R3: When eligible sources have equal mode and level, the one with the larger index wins.
- R4: `trap_req` is 1 only if the winner's level is strictly greater than `thresh` and strictly greater than `active_lvl`.
- R5: The trap also needs a privilege condition: either the winner's mode is greater than `cur_priv`, or it equals `cur_priv` and bit `mode_ie[winner mode]` is 1. A winner whose mode is below `cur_priv` never traps.
- R6: A write loads the interlock with DEPTH = ceil(log2(NSRC)/2). `busy` is 1 for exactly DEPTH cycles after the last write edge, and a write made while busy restarts the full window.
- R7: While `busy` is 1, `nxt_valid` and `trap_req` are 0.
- R8: In the first cycle with `busy` at 0 after a write, the outputs reflect that write. For example, clearing the enable flag of the current winner removes it from `nxt_id` at once.
- R9: After reset all fields are 0 and `busy` is 0. Whenever `nxt_valid` is 0, `nxt_id`, `nxt_mode` and `nxt_level` read 0.
- R10: A write whose index is NSRC or above changes no source. It still starts the busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Field write strobe |
| wr_idx | input | ID_W | Source index written |
| wr_pend | input | 1 | New pending flag |
| wr_enable | input | 1 | New enable flag |
| wr_mode | input | MODE_W | New target mode |
| wr_level | input | LVL_W | New level |
| cur_priv | input | MODE_W | Current privilege mode |
| thresh | input | LVL_W | Interrupt level threshold |
| active_lvl | input | LVL_W | Level of the interrupt in service |
| mode_ie | input | 2**MODE_W | Global interrupt enable per mode |
| busy | output | 1 | Write still propagating through the tree |
| nxt_valid | output | 1 | A winner is present and settled |
| nxt_id | output | ID_W | Winner index |
| nxt_mode | output | MODE_W | Winner mode |
| nxt_level | output | LVL_W | Winner level |
| trap_req | output | 1 | Qualified trap request |

## Verification
The bench builds the block with NSRC = 40, MODE_W = 2 and LVL_W = 8. The source count is not a power of two, so the tree has padding leaves. The 6-bit index port can then address the unused indices 40 to 63, which exercises the out-of-range write rule. With six comparison levels, DEPTH is 3. This gives a busy window long enough to see the counting, the reload on back-to-back writes and the output gating on every stalled cycle. The two mode bits give four privilege levels, so the bench can cover mode above, equal to and below the current privilege under random stimulus.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

   // floor(log2(v)) for v >= 1, used to find a tree node's height
   function automatic int flog2(input int v);
      int r;
      int t;
      r = 0;
      t = v;
      while (t > 1) begin
         t = t >> 1;
         r++;
      end
      return r;
   endfunction

   // number of register stages for a radix-2 tree of the given leaf count
   function automatic int pipe_depth(input int nsrc);
      return ($clog2(nsrc) + 1) / 2;
   endfunction

endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs #(
   parameter int NSRC   = 64,
   parameter int MODE_W = 2,
   parameter int LVL_W  = 8,
   parameter int ID_W   = $clog2(NSRC)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ID_W-1:0]        wr_idx,
   input  logic                   wr_pend,
   input  logic                   wr_enable,
   input  logic [MODE_W-1:0]      wr_mode,
   input  logic [LVL_W-1:0]       wr_level,
   output logic [NSRC-1:0]        cand,
   output logic [NSRC*MODE_W-1:0] modes,
   output logic [NSRC*LVL_W-1:0]  lvls
);

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      logic              pend_q;
      logic              ena_q;
      logic [MODE_W-1:0] mode_q;
      logic [LVL_W-1:0]  lvl_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q <= 1'b0;
            ena_q  <= 1'b0;
            mode_q <= '0;
            lvl_q  <= '0;
         end else if (wr_en && (wr_idx == ID_W'(s))) begin
            pend_q <= wr_pend;
            ena_q  <= wr_enable;
            mode_q <= wr_mode;
            lvl_q  <= wr_level;
         end
      end

      assign cand[s]                    = pend_q & ena_q;
      assign modes[s*MODE_W +: MODE_W]  = mode_q;
      assign lvls[s*LVL_W +: LVL_W]     = lvl_q;
   end

endmodule

// File: rtl/irq_rank_tree.sv
module irq_rank_tree
   import irq_sel_pkg::*;
#(
   parameter int NSRC   = 64,
   parameter int MODE_W = 2,
   parameter int LVL_W  = 8,
   parameter int ID_W   = $clog2(NSRC)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NSRC-1:0]        cand,
   input  logic [NSRC*MODE_W-1:0] modes,
   input  logic [NSRC*LVL_W-1:0]  lvls,
   output logic                   win_valid,
   output logic [MODE_W-1:0]      win_mode,
   output logic [LVL_W-1:0]       win_lvl,
   output logic [ID_W-1:0]        win_id
);

   localparam int LOG = $clog2(NSRC);
   localparam int NP  = 1 << LOG;

   typedef struct packed {
      logic              v;
      logic [MODE_W-1:0] m;
      logic [LVL_W-1:0]  l;
      logic [ID_W-1:0]   id;
   } node_t;

   // b always covers the higher indices, so ">=" on level favours it on ties
   function automatic node_t pick(input node_t a, input node_t b);
      if (b.v && (!a.v || (b.m > a.m) || ((b.m == a.m) && (b.l >= a.l))))
         return b;
      return a;
   endfunction

   node_t cmb [1:2*NP-1];
   node_t nd  [1:2*NP-1];

   for (genvar i = NP; i < 2*NP; i++) begin : g_leaf
      if (i - NP < NSRC) begin : g_real
         assign cmb[i] = '{v:  cand[i-NP],
                           m:  modes[(i-NP)*MODE_W +: MODE_W],
                           l:  lvls[(i-NP)*LVL_W +: LVL_W],
                           id: ID_W'(i-NP)};
      end else begin : g_pad
         assign cmb[i] = '0;
      end
      assign nd[i] = cmb[i];
   end

   for (genvar i = 1; i < NP; i++) begin : g_node
      localparam int H = LOG - flog2(i);
      assign cmb[i] = pick(nd[2*i], nd[2*i+1]);
      if ((H % 2 == 0) || (H == LOG)) begin : g_reg
         node_t q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= cmb[i];
         end
         assign nd[i] = q;
      end else begin : g_comb
         assign nd[i] = cmb[i];
      end
   end

   assign win_valid = nd[1].v;
   assign win_mode  = nd[1].m;
   assign win_lvl   = nd[1].l;
   assign win_id    = nd[1].id;

endmodule

// File: rtl/irq_hazard_ctr.sv
module irq_hazard_ctr #(
   parameter int DEPTH = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   output logic busy
);

   localparam int CW = $clog2(DEPTH + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (wr_en)      cnt <= CW'(DEPTH);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (cnt == CW'(DEPTH)));

   assert_countdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && busy) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/irq_select_top.sv
module irq_select_top
   import irq_sel_pkg::*;
#(
   parameter int NSRC   = 64,
   parameter int MODE_W = 2,
   parameter int LVL_W  = 8,
   parameter int ID_W   = $clog2(NSRC)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ID_W-1:0]        wr_idx,
   input  logic                   wr_pend,
   input  logic                   wr_enable,
   input  logic [MODE_W-1:0]      wr_mode,
   input  logic [LVL_W-1:0]       wr_level,
   input  logic [MODE_W-1:0]      cur_priv,
   input  logic [LVL_W-1:0]       thresh,
   input  logic [LVL_W-1:0]       active_lvl,
   input  logic [(1<<MODE_W)-1:0] mode_ie,
   output logic                   busy,
   output logic                   nxt_valid,
   output logic [ID_W-1:0]        nxt_id,
   output logic [MODE_W-1:0]      nxt_mode,
   output logic [LVL_W-1:0]       nxt_level,
   output logic                   trap_req
);

   localparam int DEPTH = pipe_depth(NSRC);

   if (NSRC < 2 || NSRC > 4096) begin : g_bad_nsrc
      $error("irq_select_top: NSRC must lie in 2..4096");
   end
   if (ID_W < $clog2(NSRC)) begin : g_bad_idw
      $error("irq_select_top: ID_W too narrow for NSRC");
   end
   if (MODE_W < 1 || LVL_W < 1) begin : g_bad_fields
      $error("irq_select_top: field widths must be positive");
   end

   logic [NSRC-1:0]        cand;
   logic [NSRC*MODE_W-1:0] modes;
   logic [NSRC*LVL_W-1:0]  lvls;
   logic                   win_valid;
   logic [MODE_W-1:0]      win_mode;
   logic [LVL_W-1:0]       win_lvl;
   logic [ID_W-1:0]        win_id;

   irq_src_regs #(.NSRC(NSRC), .MODE_W(MODE_W), .LVL_W(LVL_W), .ID_W(ID_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_pend(wr_pend), .wr_enable(wr_enable), .wr_mode(wr_mode), .wr_level(wr_level),
      .cand(cand), .modes(modes), .lvls(lvls));

   irq_rank_tree #(.NSRC(NSRC), .MODE_W(MODE_W), .LVL_W(LVL_W), .ID_W(ID_W)) u_tree (
      .clk(clk), .rst_n(rst_n), .cand(cand), .modes(modes), .lvls(lvls),
      .win_valid(win_valid), .win_mode(win_mode), .win_lvl(win_lvl), .win_id(win_id));

   irq_hazard_ctr #(.DEPTH(DEPTH)) u_hzd (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy));

   logic lvl_ok;
   logic priv_ok;

   always_comb begin
      nxt_valid = win_valid & ~busy;
      nxt_id    = nxt_valid ? win_id   : '0;
      nxt_mode  = nxt_valid ? win_mode : '0;
      nxt_level = nxt_valid ? win_lvl  : '0;
      lvl_ok    = (win_lvl > thresh) && (win_lvl > active_lvl);
      priv_ok   = (win_mode > cur_priv) || ((win_mode == cur_priv) && mode_ie[win_mode]);
      trap_req  = nxt_valid & lvl_ok & priv_ok;
   end

   assert_stall_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!nxt_valid && !trap_req));

   assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !nxt_valid |-> (nxt_id == '0 && nxt_mode == '0 && nxt_level == '0));

   assert_winner_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
      nxt_valid |-> cand[nxt_id]);

   assert_winner_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
      nxt_valid |-> (modes[nxt_id*MODE_W +: MODE_W] == nxt_mode &&
                     lvls[nxt_id*LVL_W +: LVL_W] == nxt_level));

endmodule

// File: tb/tb_irq_select_top.sv
module tb_irq_select_top;
   localparam int NS  = 40;
   localparam int MW  = 2;
   localparam int LW  = 8;
   localparam int IW  = 6;
   localparam int DEP = 3;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, wr_en, wr_pend, wr_enable;
   logic [IW-1:0] wr_idx;
   logic [MW-1:0] wr_mode, cur_priv;
   logic [LW-1:0] wr_level, thresh, active_lvl;
   logic [3:0]    mode_ie;
   logic busy, nxt_valid, trap_req;
   logic [IW-1:0] nxt_id;
   logic [MW-1:0] nxt_mode;
   logic [LW-1:0] nxt_level;

   irq_select_top #(.NSRC(NS), .MODE_W(MW), .LVL_W(LW), .ID_W(IW)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_pend(wr_pend),
      .wr_enable(wr_enable), .wr_mode(wr_mode), .wr_level(wr_level), .cur_priv(cur_priv),
      .thresh(thresh), .active_lvl(active_lvl), .mode_ie(mode_ie), .busy(busy),
      .nxt_valid(nxt_valid), .nxt_id(nxt_id), .nxt_mode(nxt_mode), .nxt_level(nxt_level),
      .trap_req(trap_req));

   int checks = 0;
   int errors = 0;
   bit mp [NS];
   bit me [NS];
   int mm [NS];
   int ml [NS];

   task automatic chk(input bit ok, input string req, input string what, input int got, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
      end
   endtask

   function automatic void model(output bit v, output int id, output int m, output int l);
      v = 0; id = 0; m = 0; l = 0;
      for (int s = 0; s < NS; s++) begin
         if (mp[s] && me[s] && (!v || mm[s] > m || (mm[s] == m && ml[s] >= l))) begin
            v = 1; id = s; m = mm[s]; l = ml[s];
         end
      end
   endfunction

   function automatic bit trap_model(input bit v, input int m, input int l);
      return v && (l > int'(thresh)) && (l > int'(active_lvl)) &&
             ((m > int'(cur_priv)) || (m == int'(cur_priv) && mode_ie[m]));
   endfunction

   // write ends at the negedge after the write edge
   task automatic wr(input int idx, input bit p, input bit e, input int m, input int l);
      wr_en = 1; wr_idx = IW'(idx); wr_pend = p; wr_enable = e;
      wr_mode = MW'(m); wr_level = LW'(l);
      @(negedge clk);
      wr_en = 0;
      if (idx < NS) begin mp[idx] = p; me[idx] = e; mm[idx] = m; ml[idx] = l; end
   endtask

   // counts busy cycles; outputs must stay gated throughout
   task automatic settle(input string req);
      int n = 0;
      bit gated = 1;
      while (busy && n < 50) begin
         if (nxt_valid || trap_req) gated = 0;
         n++;
         @(negedge clk);
      end
      chk(n == DEP, req, "busy cycles", n, DEP);
      chk(gated, "R7", "outputs gated while busy", int'(gated), 1);
   endtask

   task automatic check_out(input string req);
      bit v; int id, m, l;
      model(v, id, m, l);
      #1;
      chk(nxt_valid == v, req, "nxt_valid", int'(nxt_valid), int'(v));
      chk(int'(nxt_id) == id, req, "nxt_id", int'(nxt_id), id);
      chk(int'(nxt_mode) == m && int'(nxt_level) == l, req, "mode*256+level",
          int'(nxt_mode)*256 + int'(nxt_level), m*256 + l);
      chk(trap_req == trap_model(v, m, l), "R4/R5", "trap_req", int'(trap_req),
          int'(trap_model(v, m, l)));
   endtask

   task automatic env(input int p, input int th, input int ac, input int ie);
      cur_priv = MW'(p); thresh = LW'(th); active_lvl = LW'(ac); mode_ie = 4'(ie);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(20 * 190000);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int s = 0; s < NS; s++) begin mp[s] = 0; me[s] = 0; mm[s] = 0; ml[s] = 0; end
      rst_n = 0; wr_en = 0; wr_idx = '0; wr_pend = 0; wr_enable = 0; wr_mode = '0; wr_level = '0;
      env(0, 0, 0, 4'hF);
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(!busy && !nxt_valid && !trap_req, "R9", "reset busy/valid/trap", int'(busy|nxt_valid|trap_req), 0);
      chk(nxt_id == '0, "R9", "reset id", int'(nxt_id), 0);
      rst_n = 1;
      @(negedge clk);
      check_out("R9");

      // R10 out-of-range index does nothing but starts the window
      wr(45, 1, 1, 3, 200);
      settle("R10");
      check_out("R10");

      // R1 eligibility needs both flags
      wr(3, 1, 0, 3, 1);  settle("R6"); check_out("R1");
      wr(3, 1, 1, 3, 1);  settle("R6"); check_out("R1");
      wr(2, 0, 1, 3, 99); settle("R6"); check_out("R1");

      // R2 mode outranks level, then level
      wr(7, 1, 1, 1, 10); settle("R6"); check_out("R2");
      wr(9, 1, 1, 3, 50); settle("R6"); check_out("R2");

      // R3 tie goes to higher index
      wr(20, 1, 1, 3, 50); settle("R6"); check_out("R3");
      chk(nxt_id == 20, "R3", "tie winner", int'(nxt_id), 20);
      wr(4, 1, 1, 3, 50);  settle("R6"); check_out("R3");

      // R8 disabling the winner is visible on the first settled cycle
      wr(20, 1, 0, 3, 50); settle("R8"); check_out("R8");
      chk(nxt_id == 9, "R8", "winner after disable", int'(nxt_id), 9);

      // R6 back-to-back writes reload the window
      wr_en = 1; wr_idx = 6'd11; wr_pend = 1; wr_enable = 1; wr_mode = 2'd3; wr_level = 8'd77;
      @(negedge clk);
      mp[11] = 1; me[11] = 1; mm[11] = 3; ml[11] = 77;
      wr(12, 1, 1, 2, 255);
      settle("R6"); check_out("R6");

      // R4 / R5 directed trap qualification, winner is src 11 mode 3 level 77
      env(3, 76, 0, 4'h8);  check_out("R4");
      env(3, 77, 0, 4'h8);  check_out("R4");
      env(3, 0, 77, 4'h8);  check_out("R4");
      env(3, 0, 76, 4'h0);  check_out("R5");
      env(1, 0, 0, 4'h0);   check_out("R5");
      wr(11, 0, 1, 3, 77); wr(9, 0, 0, 0, 0); wr(4, 0, 0, 0, 0); wr(3, 0, 0, 0, 0);
      settle("R6");
      env(3, 0, 0, 4'hF);   check_out("R5"); // winner src 12 mode 2 below priv 3

      // random mix
      for (int it = 0; it < 300; it++) begin
         wr(int'($urandom_range(47, 0)), 1'($urandom_range(3, 0) != 0), 1'($urandom_range(3, 0) != 0),
            int'($urandom_range(3, 0)), int'($urandom_range(255, 0)));
         settle("R6");
         for (int k = 0; k < 3; k++) begin
            env(int'($urandom_range(3, 0)), int'($urandom_range(255, 0)),
                int'($urandom_range(255, 0)), int'($urandom_range(15, 0)));
            check_out("R2");
            @(negedge clk);
         end
      end
      finish_run();
   end
endmodule